// File: doc/BRIEF.md
# Converter Output Latency and Polarity Stage

This block takes the 8-bit result of a pixel converter and presents it on the shared output data bus. Each code is captured on the falling edge of the converter clock and travels through a delay line whose length is set by the sampling configuration. With one channel, or with three channels rotated line by line, the delay is a fixed number of clock cycles. With two or three channels rotated pixel by pixel, the delay is a fixed number of pixel periods, and each period is two or three clocks long. A polarity bit can replace the code with its bitwise complement. Signals referenced to the top of the converter range are inverted this way, so that a zero input still reads as code 0.

The bus driver enable goes low whenever the line-sync input is high or the output-disable control bit is set. The same wires can then carry a serial control load. A valid flag travels with each output word. It marks words whose samples were taken after the most recent reset, line-sync or configuration change, once the whole delay line has refilled since that event.

Top module: `outlat_stage`

## Requirements
- R1: In configurations 00 and 11, the code sampled at a falling clock edge appears on `dataOut` right after the falling edge 8 cycles later, and it is held across the rising edge in between.
- R2: In configuration 01 (2-clock pixels), the delay is 6 pixels, which is 12 falling edges.
- R3: In configuration 10 (3-clock pixels), the delay is 6 pixels, which is 18 falling edges.
- R4: When `invertEn` is 1 at the falling edge that updates `dataOut`, the word driven is the bitwise complement of the delayed code. When it is 0, the word is the code unchanged.
- R5: While `lineSync` is 1, `dataOe` is 0.
- R6: While `outDisable` is 1, `dataOe` is 0. With both `lineSync` and `outDisable` at 0, `dataOe` is 1. Neither input alters `dataOut`.
- R7: `validOut` is 1 after falling edge n only if no reset, no `lineSync` high and no configuration change occurred at any falling edge from n-L through n, where L is the delay of the current configuration. Otherwise it is 0.
- R8: A change of `cfgMode` between two falling edges clears `validOut` at the next edge. It stays 0 until L new samples have been taken.
- R9: During reset, `dataOut` is 0 and `validOut` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock; capture and output update on its falling edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rawCode | input | 8 | Conversion result for the current sample |
| lineSync | input | 1 | Line start; releases the bus and restarts validity |
| invertEn | input | 1 | Polarity control: 1 complements the output code |
| outDisable | input | 1 | Control bit that releases the bus |
| cfgMode | input | 2 | Sampling configuration: 00 single, 01 dual pixel, 10 triple pixel, 11 triple line |
| dataOut | output | 8 | Delayed and polarity-corrected code |
| dataOe | output | 1 | Bus driver enable for the pads |
| validOut | output | 1 | Marks `dataOut` as a word taken after a full refill |

## Verification
The assertions assume that `lineSync`, `cfgMode`, `invertEn` and `rawCode` change only between a rising edge and the following falling edge, and that reset is released away from a falling edge. Given that, each falling edge sees one clean value of every input. The stimulus applies all inputs one nanosecond after a rising edge, so they are settled well before the falling edge half a period later. The bench then samples outputs at that point, after the data changed on the preceding falling edge.

// File: rtl/outlat_pkg.sv
package outlat_pkg;

  typedef enum logic [1:0] {
    CFG_ONE        = 2'b00,
    CFG_TWO_PIX    = 2'b01,
    CFG_THREE_PIX  = 2'b10,
    CFG_THREE_LINE = 2'b11
  } cfg_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       flush;   // drop every pending valid mark
    logic       invert;  // complement the word being launched
    logic [2:0] tapSel;  // one-hot: cycle tap, 2-clock pixel tap, 3-clock pixel tap
  } strobe_t;

endpackage

// File: rtl/outlat_ctrl.sv
module outlat_ctrl
  import outlat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineSync,
  input  logic       invertEn,
  input  logic [1:0] cfgMode,
  output strobe_t    strb
);

  logic [1:0] cfgPrev;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) cfgPrev <= '0;
    else       cfgPrev <= cfgMode;
  end

  always_comb begin
    strb.flush  = lineSync || (cfgMode != cfgPrev);
    strb.invert = invertEn;
    case (cfg_e'(cfgMode))
      CFG_TWO_PIX:   strb.tapSel = 3'b010;
      CFG_THREE_PIX: strb.tapSel = 3'b100;
      default:       strb.tapSel = 3'b001;
    endcase
  end

endmodule

// File: rtl/outlat_dpath.sv
module outlat_dpath
  import outlat_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_LAT = 8,
  parameter int PIX_LAT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rawCode,
  input  strobe_t           strb,
  output logic [DATA_W-1:0] dataOut,
  output logic              validOut
);

  localparam int TAP_CYC = CLK_LAT - 1;
  localparam int TAP_P2  = 2 * PIX_LAT - 1;
  localparam int TAP_P3  = 3 * PIX_LAT - 1;
  localparam int DEPTH   = (CLK_LAT > 3 * PIX_LAT) ? CLK_LAT : 3 * PIX_LAT;

  logic [DEPTH-1:0][DATA_W-1:0] dLine;
  logic [DEPTH-1:0]             vLine;
  logic [DATA_W-1:0]            tapData;
  logic                         tapValid;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      dLine <= '0;
      vLine <= '0;
    end else begin
      dLine <= {dLine[DEPTH-2:0], rawCode};
      vLine <= strb.flush ? '0 : {vLine[DEPTH-2:0], 1'b1};
    end
  end

  always_comb begin
    if (strb.tapSel[1]) begin
      tapData  = dLine[TAP_P2];
      tapValid = vLine[TAP_P2];
    end else if (strb.tapSel[2]) begin
      tapData  = dLine[TAP_P3];
      tapValid = vLine[TAP_P3];
    end else begin
      tapData  = dLine[TAP_CYC];
      tapValid = vLine[TAP_CYC];
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut  <= '0;
      validOut <= 1'b0;
    end else begin
      dataOut  <= strb.invert ? ~tapData : tapData;
      validOut <= tapValid && !strb.flush;
    end
  end

  // R1 R2 R3: exactly one delay tap is chosen
  a_r1_one_tap: assert property (@(negedge clk) disable iff (!rstN)
    $countones(strb.tapSel) == 1);

endmodule

// File: rtl/outlat_stage.sv
module outlat_stage
  import outlat_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_LAT = 8,
  parameter int PIX_LAT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rawCode,
  input  logic              lineSync,
  input  logic              invertEn,
  input  logic              outDisable,
  input  logic [1:0]        cfgMode,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              validOut
);

  strobe_t strb;

  outlat_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lineSync (lineSync),
    .invertEn (invertEn),
    .cfgMode  (cfgMode),
    .strb     (strb)
  );

  outlat_dpath #(
    .DATA_W  (DATA_W),
    .CLK_LAT (CLK_LAT),
    .PIX_LAT (PIX_LAT)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .rawCode  (rawCode),
    .strb     (strb),
    .dataOut  (dataOut),
    .validOut (validOut)
  );

  assign dataOe = !lineSync && !outDisable;

  // R5: sync releases the bus
  a_r5_sync_release: assert property (@(posedge clk) disable iff (!rstN)
    lineSync |-> !dataOe);

  // R6: the disable bit releases the bus
  a_r6_disable_release: assert property (@(posedge clk) disable iff (!rstN)
    outDisable |-> !dataOe);

  // R7: a valid word never follows an edge that saw sync high
  a_r7_valid_quiet: assert property (@(negedge clk) disable iff (!rstN)
    validOut |-> $past(!lineSync));

  // R8: configuration change clears validity at the next edge
  a_r8_cfg_flush: assert property (@(negedge clk) disable iff (!rstN)
    (cfgMode != $past(cfgMode)) |=> !validOut);

endmodule

// File: tb/sim_outlat_stage.sv
`timescale 1ns/100ps
module sim_outlat_stage;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] rawCode = 8'h00;
  logic       lineSync = 1'b0;
  logic       invertEn = 1'b0;
  logic       outDisable = 1'b0;
  logic [1:0] cfgMode = 2'b00;
  logic [7:0] dataOut;
  logic       dataOe;
  logic       validOut;

  always #2.5 clk = ~clk;

  outlat_stage u0 (
    .clk        (clk),
    .rstN       (rstN),
    .rawCode    (rawCode),
    .lineSync   (lineSync),
    .invertEn   (invertEn),
    .outDisable (outDisable),
    .cfgMode    (cfgMode),
    .dataOut    (dataOut),
    .dataOe     (dataOe),
    .validOut   (validOut)
  );

  int checks = 0;
  int errs = 0;
  logic [7:0] codeAt [0:2047];
  logic       invAt  [0:2047];
  logic [1:0] cfgAt  [0:2047];
  int idx = 0;
  int lastClr = 0;
  logic [1:0] prevCfg = 2'b00;
  string validTag = "R7";

  // history of what each falling edge saw
  always @(negedge clk) begin
    codeAt[idx & 2047] = rawCode;
    invAt[idx & 2047]  = invertEn;
    cfgAt[idx & 2047]  = cfgMode;
    if (!rstN || lineSync || (cfgMode != prevCfg)) lastClr = idx;
    prevCfg = rstN ? cfgMode : 2'b00;
    idx = idx + 1;
  end

  function automatic int latOf(input logic [1:0] c);
    if (c == 2'b01) return 12;
    if (c == 2'b10) return 18;
    return 8;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
  endtask

  // one cycle: sample outputs after the rising edge, before the falling edge
  task automatic step();
    int n;
    int lat;
    logic expValid;
    logic [7:0] expData;
    string dTag;
    @(posedge clk);
    #1;
    n = idx - 1;
    if (!rstN) begin
      check("R9", "reset dataOut", 32'(dataOut), 32'h0);
      check("R9", "reset validOut", 32'(validOut), 32'h0);
    end else begin
      lat = latOf(cfgAt[n & 2047]);
      expValid = (n - lat > lastClr);
      check(validTag, "validOut", 32'(validOut), 32'(expValid));
      if (expValid) begin
        expData = codeAt[(n - lat) & 2047];
        if (invAt[n & 2047]) expData = ~expData;
        if (invAt[n & 2047])                    dTag = "R4";
        else if (cfgAt[n & 2047] == 2'b01)      dTag = "R2";
        else if (cfgAt[n & 2047] == 2'b10)      dTag = "R3";
        else                                    dTag = "R1";
        check(dTag, "dataOut", 32'(dataOut), 32'(expData));
      end
    end
    check(lineSync ? "R5" : "R6", "dataOe", 32'(dataOe),
          32'(!lineSync && !outDisable));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (4) step();
    rstN = 1'b1;

    // R1 R2 R3 R4 R5 R6 R7: every configuration, both polarities
    for (int c = 0; c < 4; c++) begin
      for (int v = 0; v < 2; v++) begin
        cfgMode  = 2'(c);
        invertEn = v[0];
        lineSync = 1'b1;
        step();
        step();
        lineSync = 1'b0;
        for (int k = 0; k < 48; k++) begin
          rawCode    = 8'((k * 37 + c * 11 + v * 91 + 5) & 255);
          outDisable = (k >= 10 && k < 14);
          lineSync   = (k == 30);
          step();
        end
        outDisable = 1'b0;
        lineSync = 1'b0;
      end
    end

    // R1 R4: every code, polarity flipped each cycle
    cfgMode = 2'b00;
    lineSync = 1'b1;
    step();
    lineSync = 1'b0;
    for (int k = 0; k < 264; k++) begin
      rawCode  = 8'(k & 255);
      invertEn = k[0];
      step();
    end
    invertEn = 1'b0;

    // R8: configuration change with no sync
    validTag = "R8";
    cfgMode = 2'b01;
    for (int k = 0; k < 20; k++) begin
      rawCode = 8'((k * 53 + 7) & 255);
      step();
    end
    cfgMode = 2'b10;
    for (int k = 0; k < 26; k++) begin
      rawCode = 8'((k * 29 + 3) & 255);
      step();
    end
    cfgMode = 2'b11;
    for (int k = 0; k < 14; k++) begin
      rawCode = 8'((k * 71 + 1) & 255);
      step();
    end

    summary();
    $finish;
  end

endmodule